// File: doc/BRIEF.md
# Clock and Power-Mode Controller

This block takes the free-running oscillator clock and produces single-cycle clock enables. One enable goes to the processor core and one to the peripherals. A further pulse marks each machine-cycle boundary. Internally the oscillator is halved: an enable pulse can occur at most on every other oscillator cycle. One machine cycle is a fixed number of these internal states, six by default, which makes twelve oscillator periods. All logic is static. Stopping an enable freezes the state it governs, and that state is not lost.

Software selects a low-power state by writing a two-bit power-control value:
- **Idle** removes only the core enable. Peripherals and interrupt logic keep running, and a pending interrupt wakes the core.
- **Power-down** removes every enable and drops the oscillator-run request. Interrupts cannot wake it; only a reset can.

The raw reset pin is synchronised first. The block raises its internal reset only after the synchronised level has stayed high for a set number of machine cycles. A qualified reset returns the block to the running state.

Top module: `clkpwr_ctrl`

## Requirements
- R1: While running, `core_en` and `periph_en` are never high on two consecutive oscillator cycles, and each is high on exactly 12 of any 24 consecutive cycles.
- R2: While the oscillator runs, `mc_tick` pulses once every STATES_PER_MC×2 oscillator cycles (4 pulses per 48 cycles by default).
- R3: A write with `pcon_wdata` = 2'b01 (bit 0 = idle, bit 1 = power-down) enters idle. `core_en` then stays low and `periph_en` keeps its R1 rate.
- R4: While idle, a one-cycle `irq_pending` pulse clears idle, and `core_en` resumes at the R1 rate.
- R5: A write with bit 1 set enters power-down. `core_en`, `periph_en` and `mc_tick` then stay low, and `osc_run` drops to 0. An `irq_pending` pulse has no effect, and the state holds.
- R6: A write of 2'b11 enters power-down only, so power-down takes priority; idle stays clear.
- R7: `rst_pin` passes through SYNC_STAGES flops. `int_rst` rises only after the synchronised level has been high across RST_MC `mc_tick` pulses, which is between 14 and 30 cycles after the pin rises by default. A pulse of 10 cycles never raises `int_rst` and leaves power-down set.
- R8: While the synchronised reset is high, `osc_run` is 1 so that the reset can be counted. A qualified reset clears both mode bits, and `int_rst` falls shortly after the pin falls.
- R9: After `sys_rst`, `int_rst` is 0, `osc_run` is 1 and both mode bits are clear, so the core runs at the R1 rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| sys_rst | input | 1 | Synchronous active-high block reset |
| rst_pin | input | 1 | Raw asynchronous reset pin, active high |
| irq_pending | input | 1 | Some interrupt is pending |
| pcon_wr | input | 1 | Write strobe for the power-control value |
| pcon_wdata | input | 2 | Bit 0 idle request, bit 1 power-down request |
| core_en | output | 1 | Core clock enable |
| periph_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator-run request |
| mc_tick | output | 1 | Machine-cycle boundary pulse |
| int_rst | output | 1 | Qualified, synchronised internal reset |

## Verification
The bench builds the block with its defaults: six states per machine cycle, two machine cycles for reset qualification and two synchroniser stages. This keeps a whole machine cycle within twelve oscillator cycles. Enable rates can then be checked by counting pulses over short windows. The default values also bring both reset cases within reach in a few dozen cycles: a pulse too short to qualify, and a pulse long enough whose recognition latency falls in a computable window. The wake rules are exercised from both low-power states, and so is the priority of a combined write.

// File: rtl/clkpwr_pkg.sv
package clkpwr_pkg;
  localparam int unsigned BIT_IDLE = 0;
  localparam int unsigned BIT_PD   = 1;
  localparam int unsigned PCON_W   = 2;

  typedef struct packed {
    logic pd;
    logic idle;
  } mode_t;
endpackage

// File: rtl/cp_divider.sv
module cp_divider #(
  parameter int unsigned STATES_PER_MC = 6
) (
  input  logic clk,
  input  logic sys_rst,
  input  logic run,
  output logic tick_pre,
  output logic mc_last
);
  localparam int unsigned SW = (STATES_PER_MC > 1) ? $clog2(STATES_PER_MC) : 1;
  localparam logic [SW-1:0] LAST = SW'(STATES_PER_MC - 1);

  logic          phase_q;
  logic [SW-1:0] state_q;

  assign tick_pre = run && phase_q;
  assign mc_last  = (state_q == LAST);

  always_ff @(posedge clk) begin
    if (sys_rst) begin
      phase_q <= 1'b0;
      state_q <= '0;
    end else if (run) begin
      phase_q <= ~phase_q;
      if (phase_q) begin
        if (state_q == LAST) state_q <= '0;
        else                 state_q <= state_q + 1'b1;
      end
    end
  end

  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (sys_rst)
    state_q <= LAST); // R2
endmodule

// File: rtl/cp_rst_qual.sv
module cp_rst_qual #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_MC      = 2
) (
  input  logic clk,
  input  logic sys_rst,
  input  logic rst_pin,
  input  logic mc_tick,
  output logic rst_sync,
  output logic int_rst
);
  localparam int unsigned CW = $clog2(RST_MC + 1);
  localparam logic [CW-1:0] CMAX = CW'(RST_MC);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   int_rst_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (sys_rst) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= rst_pin;
        else             sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign rst_sync = sync_q[SYNC_STAGES-1];
  assign int_rst  = int_rst_q;

  always_ff @(posedge clk) begin
    if (sys_rst || !rst_sync) begin
      cnt_q     <= '0;
      int_rst_q <= 1'b0;
    end else begin
      if (mc_tick && cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
      int_rst_q <= (cnt_q == CMAX);
    end
  end

  AST_RST_DROP: assert property (@(posedge clk) disable iff (sys_rst)
    !rst_sync |=> !int_rst); // R7
endmodule

// File: rtl/cp_mode_reg.sv
module cp_mode_reg
  import clkpwr_pkg::*;
(
  input  logic              clk,
  input  logic              sys_rst,
  input  logic              int_rst,
  input  logic              pcon_wr,
  input  logic [PCON_W-1:0] pcon_wdata,
  input  logic              irq_pending,
  output mode_t             mode_q,
  output mode_t             mode_d
);
  always_comb begin
    mode_d = mode_q;
    if (int_rst) begin
      mode_d = '0;
    end else if (pcon_wr) begin
      mode_d.pd   = pcon_wdata[BIT_PD];
      mode_d.idle = pcon_wdata[BIT_IDLE] && !pcon_wdata[BIT_PD];
    end else if (irq_pending && mode_q.idle) begin
      mode_d.idle = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (sys_rst) mode_q <= '0;
    else         mode_q <= mode_d;
  end

  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (sys_rst)
    int_rst |=> (!mode_q.idle && !mode_q.pd)); // R8
  AST_PD_PRIO: assert property (@(posedge clk) disable iff (sys_rst)
    (pcon_wr && pcon_wdata[BIT_PD] && !int_rst) |=> (mode_q.pd && !mode_q.idle)); // R6
  AST_PD_HOLD: assert property (@(posedge clk) disable iff (sys_rst)
    (mode_q.pd && !int_rst && !pcon_wr) |=> mode_q.pd); // R5
endmodule

// File: rtl/clkpwr_ctrl.sv
module clkpwr_ctrl
  import clkpwr_pkg::*;
#(
  parameter int unsigned STATES_PER_MC = 6,
  parameter int unsigned RST_MC        = 2,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              sys_rst,
  input  logic              rst_pin,
  input  logic              irq_pending,
  input  logic              pcon_wr,
  input  logic [PCON_W-1:0] pcon_wdata,
  output logic              core_en,
  output logic              periph_en,
  output logic              osc_run,
  output logic              mc_tick,
  output logic              int_rst
);
  logic  tick_pre, mc_last, rst_sync;
  logic  core_en_q, periph_en_q, osc_run_q, mc_tick_q;
  mode_t mode_q, mode_d;

  cp_divider #(.STATES_PER_MC(STATES_PER_MC)) u_div (
    .clk(clk), .sys_rst(sys_rst), .run(osc_run_q),
    .tick_pre(tick_pre), .mc_last(mc_last)
  );

  cp_rst_qual #(.SYNC_STAGES(SYNC_STAGES), .RST_MC(RST_MC)) u_rq (
    .clk(clk), .sys_rst(sys_rst), .rst_pin(rst_pin), .mc_tick(mc_tick_q),
    .rst_sync(rst_sync), .int_rst(int_rst)
  );

  cp_mode_reg u_mode (
    .clk(clk), .sys_rst(sys_rst), .int_rst(int_rst), .pcon_wr(pcon_wr),
    .pcon_wdata(pcon_wdata), .irq_pending(irq_pending),
    .mode_q(mode_q), .mode_d(mode_d)
  );

  always_ff @(posedge clk) begin
    if (sys_rst) begin
      core_en_q   <= 1'b0;
      periph_en_q <= 1'b0;
      mc_tick_q   <= 1'b0;
      osc_run_q   <= 1'b1;
    end else begin
      core_en_q   <= tick_pre && !mode_d.idle && !mode_d.pd;
      periph_en_q <= tick_pre && !mode_d.pd;
      mc_tick_q   <= tick_pre && mc_last;
      osc_run_q   <= !mode_d.pd || rst_sync;
    end
  end

  assign core_en   = core_en_q;
  assign periph_en = periph_en_q;
  assign mc_tick   = mc_tick_q;
  assign osc_run   = osc_run_q;

  AST_CORE_HALF: assert property (@(posedge clk) disable iff (sys_rst)
    core_en_q |=> !core_en_q); // R1
  AST_PERIPH_HALF: assert property (@(posedge clk) disable iff (sys_rst)
    periph_en_q |=> !periph_en_q); // R1
  AST_IDLE_NO_CORE: assert property (@(posedge clk) disable iff (sys_rst)
    mode_q.idle |-> !core_en_q); // R3
  AST_PD_NO_EN: assert property (@(posedge clk) disable iff (sys_rst)
    mode_q.pd |-> (!core_en_q && !periph_en_q)); // R5
  AST_OSC_IN_RST: assert property (@(posedge clk) disable iff (sys_rst)
    rst_sync |=> osc_run_q); // R8
endmodule

// File: tb/sim_clkpwr_ctrl.sv
module sim_clkpwr_ctrl;
  logic clk = 1'b0;
  logic sys_rst = 1'b1;
  logic rst_pin = 1'b0;
  logic irq_pending = 1'b0;
  logic pcon_wr = 1'b0;
  logic [1:0] pcon_wdata = 2'b00;
  logic core_en, periph_en, osc_run, mc_tick, int_rst;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clkpwr_ctrl u0 (
    .clk(clk), .sys_rst(sys_rst), .rst_pin(rst_pin), .irq_pending(irq_pending),
    .pcon_wr(pcon_wr), .pcon_wdata(pcon_wdata), .core_en(core_en),
    .periph_en(periph_en), .osc_run(osc_run), .mc_tick(mc_tick), .int_rst(int_rst)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count(int n, output int c_core, output int c_per, output int c_mc);
    c_core = 0; c_per = 0; c_mc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c_core += int'(core_en);
      c_per  += int'(periph_en);
      c_mc   += int'(mc_tick);
    end
  endtask

  task automatic pcon_write(logic [1:0] v);
    @(negedge clk);
    pcon_wr = 1'b1; pcon_wdata = v;
    @(negedge clk);
    pcon_wr = 1'b0; pcon_wdata = 2'b00;
    wait_n(4);
  endtask

  task automatic irq_pulse();
    @(negedge clk); irq_pending = 1'b1;
    @(negedge clk); irq_pending = 1'b0;
    wait_n(4);
  endtask

  // holds the pin high for n cycles; returns whether int_rst was seen and its latency
  task automatic reset_pulse(int n, output int seen, output int lat);
    seen = 0; lat = -1;
    @(negedge clk); rst_pin = 1'b1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (int_rst && seen == 0) begin seen = 1; lat = i; end
    end
    rst_pin = 1'b0;
    wait_n(6);
  endtask

  task automatic t_reset_state();
    int c, p, m;
    check("R9 int_rst after sys_rst", int'(int_rst), 0);
    check("R9 osc_run after sys_rst", int'(osc_run), 1);
    count(24, c, p, m);
    check("R9 core runs after sys_rst", c, 12);
  endtask

  task automatic t_rates();
    int c, p, m;
    count(24, c, p, m);
    check("R1 core_en per 24", c, 12);
    check("R1 periph_en per 24", p, 12);
    count(48, c, p, m);
    check("R2 mc_tick per 48", m, 4);
  endtask

  task automatic t_idle_irq();
    int c, p, m;
    pcon_write(2'b01);
    count(24, c, p, m);
    check("R3 core_en in idle", c, 0);
    check("R3 periph_en in idle", p, 12);
    irq_pulse();
    count(24, c, p, m);
    check("R4 core_en after wake", c, 12);
  endtask

  task automatic t_pd_irq();
    int c, p, m;
    pcon_write(2'b10);
    count(24, c, p, m);
    check("R5 core_en in pd", c, 0);
    check("R5 periph_en in pd", p, 0);
    check("R5 mc_tick in pd", m, 0);
    check("R5 osc_run in pd", int'(osc_run), 0);
    irq_pulse();
    count(24, c, p, m);
    check("R5 periph_en after irq in pd", p, 0);
    check("R5 osc_run after irq in pd", int'(osc_run), 0);
  endtask

  task automatic t_short_reset();
    int s, l, c, p, m;
    reset_pulse(10, s, l);
    check("R7 short pulse no int_rst", s, 0);
    count(24, c, p, m);
    check("R7 pd kept after short pulse", p, 0);
    check("R7 osc_run low after short pulse", int'(osc_run), 0);
  endtask

  task automatic t_long_reset(string tag);
    int s, l, c, p, m;
    reset_pulse(40, s, l);
    check({tag, " R7 long pulse raises int_rst"}, s, 1);
    check({tag, " R7 latency window"}, int'(l >= 14 && l <= 30), 1);
    check({tag, " R8 int_rst falls"}, int'(int_rst), 0);
    check({tag, " R8 osc_run after reset"}, int'(osc_run), 1);
    count(24, c, p, m);
    check({tag, " R8 core runs after reset"}, c, 12);
  endtask

  task automatic t_osc_in_reset();
    @(negedge clk); rst_pin = 1'b1;
    wait_n(4);
    check("R8 osc_run forced during reset", int'(osc_run), 1);
    wait_n(36);
    rst_pin = 1'b0;
    wait_n(6);
  endtask

  task automatic t_both_bits();
    int c, p, m;
    pcon_write(2'b11);
    count(24, c, p, m);
    check("R6 periph_en after both bits", p, 0);
    check("R6 osc_run after both bits", int'(osc_run), 0);
  endtask

  initial begin
    wait_n(4);
    sys_rst = 1'b0;
    wait_n(2);
    t_reset_state();
    t_rates();
    t_idle_irq();
    t_pd_irq();
    t_short_reset();
    t_long_reset("from pd");
    t_both_bits();
    t_long_reset("after both bits");
    pcon_write(2'b10);
    t_osc_in_reset();
    t_rates();
    pcon_write(2'b01);
    t_long_reset("from idle");
    t_long_reset("while running");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule